// File: doc/BRIEF.md
# Self-Test Stimulus Sequencer for a Logic Array

This block drives a programmable AND-OR array through a deterministic self-test. It has two ring registers. The row ring sensitizes one bit line at a time, or one output row. The column ring pulls one product line low at a time with a walking zero. A small phase counter sequences three passes over the array:

1. Non-complemented bit lines, with a walking one on the row ring.
2. Complemented bit lines, with a walking zero on the row ring.
3. Output rows of the OR plane, with a walking zero on the first `N_OUT` rows.

The two rings are nested. The extra cell of the row ring steps the column ring. The wrap of the column ring steps the phase counter. Each phase change reloads the row ring and moves its feedback tap. The only test control input is therefore a single initialize level. The array and the response compactor are outside this block.

With test_init high, one pattern is presented per clock. With test_init low, the sequencer pauses and all three array controls return to normal mode. When the last column wrap of the OR-plane pass occurs, the block parks both rings at all-ones and raises a sticky done flag. Master reset restarts the test.

Top module: `pla_bist_seq`

## Requirements
- R1: After reset, row_pat has bit 0 high and all other bits low, col_pat is all ones, done is low, and the phase is the non-complemented pass.
- R2: In the non-complemented pass (true_blk=0, comp_blk=1, or_test_n=1), each row sweep takes N_IN+1 clocks. A one walks from bit 0 to bit N_IN-1, and then one clock shows all zeros.
- R3: In every pass, col_pat starts all ones. After each row sweep, a zero steps one position higher, starting at bit 0. Each pass holds N_PROD+1 column positions, the first of which is the all-ones position.
- R4: In the complemented pass (true_blk=1, comp_blk=0, or_test_n=1), each row sweep takes N_IN+1 clocks. A zero walks from bit 0 to bit N_IN-1 of an all-ones row_pat, and then one clock shows all ones.
- R5: With test_init high, {true_blk, comp_blk} reads 01, then 10, then 11 across the three passes, in that order only.
- R6: In the OR-plane pass (true_blk=1, comp_blk=1, or_test_n=0), each row sweep takes N_OUT+1 clocks. A zero walks over bits 0..N_OUT-1, and then one clock shows all ones. Bits N_OUT..N_IN-1 stay high throughout.
- R7: done rises exactly after (N_PROD+1)(2·N_IN+N_OUT+3) clocks with test_init high, and not one clock earlier.
- R8: Once done is high, row_pat and col_pat stay all ones, or_test_n is high, and done stays high until reset.
- R9: While test_init is low, true_blk and comp_blk are 0 and or_test_n is 1, and no pattern or phase state changes. Raising test_init again continues from the held pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| test_init | input | 1 | High runs the self-test; low pauses it and selects normal mode |
| row_pat | output | N_IN | Row stimulus: bit lines in the first two passes, output rows in the third |
| col_pat | output | N_PROD | Product-line stimulus, walking zero |
| true_blk | output | 1 | High forces non-complemented bit lines to zero |
| comp_blk | output | 1 | High forces complemented bit lines to zero |
| or_test_n | output | 1 | Low selects OR-plane rows for test |
| done | output | 1 | Sticky end-of-test flag |

## Verification
Two events can fall on the same clock: the final row step of the last column in a pass, and the column wrap that ends the pass. When they coincide, the column step, the phase change, the row reload and the tap move all take effect at one edge. The bench checks every pattern of a full run against a model built from pattern indices. The pattern right after each boundary must show the new controls, an all-ones column and a freshly loaded row. A second scenario drops test_init on exactly that boundary pattern. It checks that nothing advances during the pause and that the boundary is crossed correctly once the run resumes.

// File: rtl/pla_bist_pkg.sv
package pla_bist_pkg;

    // Phase code: bit 1 drives the true-line block, bit 0 the complement block.
    typedef enum logic [1:0] {
        PH_TRUE = 2'b01,
        PH_COMP = 2'b10,
        PH_ORPL = 2'b11
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   done;
    } ctrl_state_t;

endpackage

// File: rtl/pla_bist_ctrl.sv
module pla_bist_ctrl
    import pla_bist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_init,
    input  logic row_tap_hit,
    input  logic col_wrap_hit,
    output logic run,
    output logic col_step,
    output logic row_reload,
    output logic row_park,
    output logic or_mode,
    output logic walk_zero,
    output logic [1:0] phase_code,
    output logic done
);

    ctrl_state_t st_d, st_q;
    logic        phase_end;
    logic        last_phase;

    always_comb begin
        st_d       = st_q;
        run        = test_init & ~st_q.done;
        col_step   = run & row_tap_hit;
        phase_end  = col_step & col_wrap_hit;
        last_phase = (st_q.phase == PH_ORPL);
        row_reload = phase_end & ~last_phase;
        row_park   = phase_end & last_phase;
        if (phase_end) begin
            if (last_phase) begin
                st_d.done = 1'b1;
            end else begin
                st_d.phase = phase_e'(st_q.phase + 2'd1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_TRUE;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign or_mode    = (st_q.phase == PH_ORPL);
    assign walk_zero  = (st_q.phase != PH_TRUE);
    assign phase_code = st_q.phase;
    assign done       = st_q.done;

    // R5: the phase only ever moves one step forward
    p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != $past(st_q.phase)) |-> (st_q.phase == phase_e'($past(st_q.phase) + 2'd1)));

    // R8: done is sticky
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done);

    // R9: no phase movement while paused
    p_phase_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_init |=> $stable(st_q.phase));

endmodule

// File: rtl/pla_row_ring.sv
module pla_row_ring #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 2,
    localparam int ROW_W = N_IN + 1,
    localparam int TAP_W = $clog2(ROW_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             reload,
    input  logic             park,
    input  logic             or_mode,
    input  logic             walk_zero,
    output logic [ROW_W-1:0] cells,
    output logic             tap_hit
);

    typedef struct packed {
        logic [ROW_W-1:0] cells;
    } row_state_t;

    row_state_t       rs_d, rs_q;
    logic [TAP_W-1:0] tap;
    logic             act_lvl;

    always_comb begin
        rs_d    = rs_q;
        tap     = or_mode ? TAP_W'(N_OUT) : TAP_W'(N_IN);
        act_lvl = ~walk_zero;
        tap_hit = (rs_q.cells[tap] == act_lvl);
        if (park) begin
            rs_d.cells = '1;
        end else if (reload) begin
            rs_d.cells    = '1;
            rs_d.cells[0] = 1'b0;
        end else if (adv) begin
            for (int k = 0; k < ROW_W; k++) begin
                if (k == 0) begin
                    rs_d.cells[k] = rs_q.cells[tap];
                end else if (or_mode && (k > N_OUT)) begin
                    rs_d.cells[k] = 1'b1;
                end else begin
                    rs_d.cells[k] = rs_q.cells[k-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q.cells <= ROW_W'(1);
        end else begin
            rs_q <= rs_d;
        end
    end

    assign cells = rs_q.cells;

    // R2: exactly one active cell during the walking-one pass
    p_row_single_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_zero |-> ($countones(rs_q.cells) == 1));

    // R4: never more than one low cell during walking-zero passes
    p_row_single_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_zero |-> ($countones(~rs_q.cells) <= 1));

endmodule

// File: rtl/pla_col_ring.sv
module pla_col_ring #(
    parameter int N_PROD = 3,
    localparam int COL_W = N_PROD + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [COL_W-1:0] cells,
    output logic             wrap_hit
);

    typedef struct packed {
        logic [COL_W-1:0] cells;
    } col_state_t;

    col_state_t cs_d, cs_q;

    always_comb begin
        cs_d     = cs_q;
        wrap_hit = ~cs_q.cells[N_PROD-1];
        if (adv) begin
            cs_d.cells = {cs_q.cells[COL_W-2:0], cs_q.cells[COL_W-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.cells <= {1'b0, {N_PROD{1'b1}}};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cells = cs_q.cells;

    // R3: the column ring always carries exactly one zero
    p_col_one_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_q.cells) == 1);

endmodule

// File: rtl/pla_bist_seq.sv
module pla_bist_seq #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 2,
    parameter int N_PROD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_init,
    output logic [N_IN-1:0]   row_pat,
    output logic [N_PROD-1:0] col_pat,
    output logic              true_blk,
    output logic              comp_blk,
    output logic              or_test_n,
    output logic              done
);

    localparam int ROW_W = N_IN + 1;
    localparam int COL_W = N_PROD + 1;

    logic             run;
    logic             col_step;
    logic             row_reload;
    logic             row_park;
    logic             or_mode;
    logic             walk_zero;
    logic [1:0]       phase_code;
    logic             row_tap_hit;
    logic             col_wrap_hit;
    logic [ROW_W-1:0] row_cells;
    logic [COL_W-1:0] col_cells;

    pla_bist_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_init    (test_init),
        .row_tap_hit  (row_tap_hit),
        .col_wrap_hit (col_wrap_hit),
        .run          (run),
        .col_step     (col_step),
        .row_reload   (row_reload),
        .row_park     (row_park),
        .or_mode      (or_mode),
        .walk_zero    (walk_zero),
        .phase_code   (phase_code),
        .done         (done)
    );

    pla_row_ring #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT)
    ) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (run),
        .reload    (row_reload),
        .park      (row_park),
        .or_mode   (or_mode),
        .walk_zero (walk_zero),
        .cells     (row_cells),
        .tap_hit   (row_tap_hit)
    );

    pla_col_ring #(
        .N_PROD (N_PROD)
    ) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (col_step),
        .cells    (col_cells),
        .wrap_hit (col_wrap_hit)
    );

    // Rows beyond the OR-plane sweep are held inactive during that pass.
    for (genvar k = 0; k < N_IN; k++) begin : g_row_out
        if (k < N_OUT) begin : g_live
            assign row_pat[k] = row_cells[k];
        end else begin : g_masked
            assign row_pat[k] = row_cells[k] | or_mode;
        end
    end

    assign col_pat   = col_cells[N_PROD-1:0];
    assign true_blk  = phase_code[1] & test_init;
    assign comp_blk  = phase_code[0] & test_init;
    assign or_test_n = ~(test_init & or_mode & ~done);

    // R6: OR-plane selection only with both bit-line groups blocked
    p_or_sel_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !or_test_n |-> (true_blk && comp_blk));

    // R9: patterns and done hold while paused
    p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_init |=> ($stable(row_pat) && $stable(col_pat) && $stable(done)));

    // R8: patterns frozen once finished
    p_done_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(row_pat) && $stable(col_pat)));

    // R8: finished state releases OR-plane selection
    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> or_test_n);

endmodule

// File: tb/pla_bist_seq_bench.sv
`timescale 1ns/1ps
module pla_bist_seq_bench;

    localparam int NI = 4;
    localparam int NO = 2;
    localparam int NP = 3;
    localparam int LEN1  = (NP + 1) * (NI + 1);
    localparam int LEN2  = (NP + 1) * (NI + 1);
    localparam int LEN3  = (NP + 1) * (NO + 1);
    localparam int TOTAL = LEN1 + LEN2 + LEN3;
    localparam int VW    = 4 + NI + NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ti = 1'b0;
    logic [NI-1:0] row_pat;
    logic [NP-1:0] col_pat;
    logic          true_blk, comp_blk, or_test_n, done;

    int checks = 0;
    int errors = 0;
    int p = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pla_bist_seq #(.N_IN(NI), .N_OUT(NO), .N_PROD(NP)) u_pla_bist_seq (
        .clk(clk), .rst_n(rst_n), .test_init(ti),
        .row_pat(row_pat), .col_pat(col_pat),
        .true_blk(true_blk), .comp_blk(comp_blk), .or_test_n(or_test_n),
        .done(done)
    );

    // Expected {done, true_blk, comp_blk, or_test_n, row_pat, col_pat} at pattern index q.
    function automatic logic [VW-1:0] model(int q, logic t);
        logic [NI-1:0] row;
        logic [NP-1:0] col;
        logic          dn;
        int            ph, loc, rl, s, r;
        row = '1; col = '1; dn = 1'b0; loc = 0; rl = 1;
        if (q >= TOTAL) begin
            dn = 1'b1; ph = 3;
        end else if (q < LEN1) begin
            ph = 1; loc = q; rl = NI + 1;
        end else if (q < LEN1 + LEN2) begin
            ph = 2; loc = q - LEN1; rl = NI + 1;
        end else begin
            ph = 3; loc = q - LEN1 - LEN2; rl = NO + 1;
        end
        if (!dn) begin
            s = loc / rl;
            r = loc % rl;
            if (s > 0) col[s-1] = 1'b0;
            if (ph == 1) begin
                row = '0;
                if (r < NI) row[r] = 1'b1;
            end else if (r < ((ph == 3) ? NO : NI)) begin
                row[r] = 1'b0;
            end
        end
        return {dn, (ph >= 2) & t, (ph != 2) & t, ~(t & (ph == 3) & ~dn), row, col};
    endfunction

    function automatic string tag_of(int q);
        if (q < LEN1) return "R2,R3,R5";
        if (q < LEN1 + LEN2) return "R4,R3,R5";
        if (q < TOTAL) return "R6,R3,R5";
        return "R8";
    endfunction

    task automatic check(logic [VW-1:0] act, logic [VW-1:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s p=%0d actual=%b expected=%b", req, p, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] outs();
        return {done, true_blk, comp_blk, or_test_n, row_pat, col_pat};
    endfunction

    // One clock: drive test_init, compare, then count the edge.
    task automatic cyc(logic t, string req);
        @(negedge clk);
        ti = t;
        #1;
        check(outs(), model(p, t), req);
        @(posedge clk);
        if (t && p < TOTAL) p++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ti = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        p = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check(outs(), model(0, 1'b0), "R1");
        check(outs(), {1'b0, 3'b001, NI'(1), {NP{1'b1}}}, "R1,R9");
        ti = 1'b1;
        #1;
        check({true_blk, comp_blk, or_test_n}, 3'b011, "R5");
    endtask

    task automatic t_full_run();
        do_reset();
        while (p < TOTAL) begin
            if (p == TOTAL - 1) begin
                @(negedge clk); ti = 1'b1; #1;
                check({31'd0, done}, 32'd0, "R7");
                @(posedge clk); p++;
            end else begin
                cyc(1'b1, tag_of(p));
            end
        end
        @(negedge clk); #1;
        check({31'd0, done}, 32'd1, "R7");
    endtask

    task automatic t_done_hold();
        for (int i = 0; i < 6; i++) cyc(1'b1, "R8");
        for (int i = 0; i < 3; i++) cyc(1'b0, "R8,R9");
        cyc(1'b1, "R8");
    endtask

    task automatic t_pause_boundary();
        do_reset();
        while (p < LEN1 - 1) cyc(1'b1, tag_of(p));
        for (int i = 0; i < 5; i++) cyc(1'b0, "R9");
        cyc(1'b1, "R9,R5");
        for (int i = 0; i < 3; i++) cyc(1'b1, tag_of(p));
        while (p < LEN1 + LEN2 + 4) cyc(1'b1, tag_of(p));
        for (int i = 0; i < 4; i++) cyc(1'b0, "R9");
        while (p < TOTAL) cyc(1'b1, tag_of(p));
        for (int i = 0; i < 2; i++) cyc(1'b1, "R7,R8");
    endtask

    task automatic t_reset_mid_run();
        do_reset();
        while (p < LEN1 + 7) cyc(1'b1, tag_of(p));
        do_reset();
        #1;
        check(outs(), model(0, 1'b0), "R1");
        for (int i = 0; i < 8; i++) cyc(1'b1, tag_of(p));
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not end");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_full_run();
        t_done_hold();
        t_pause_boundary();
        t_reset_mid_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule